// File: doc/BRIEF.md
# Pulse Counter with Preset Interrupts

This block counts single-bit pulses up or down in a signed two's-complement accumulator and compares the count against a high preset and a low preset. A 16-bit status word gathers the direction enables, the limit flags, sticky overflow, underflow and high-reached flags, the cause of the last interrupt, and a pending/lost handshake. An interrupt request line is raised when an enabled event is recorded. A software acknowledge pulse lowers it. Whenever a counting step reaches either preset, a masked pattern is copied into a registered output port in the same cycle.

Software reaches the block through a simple word-addressed register port: address 0 is the status word, 1 the high preset, 2 the accumulator and 3 the low preset. The read data is registered. It returns the addressed word as it stood just before the clock edge that samples the address. A reconfiguration pulse resets the control and interrupt bookkeeping and leaves the sticky event flags alone. The pulse input must already be synchronised to `clk`. A count happens on each rising edge seen on it.

Top module: `pulse_preset_counter`

## Requirements
- R1: Reset gives status 0x0002 (only bit 1 set), accumulator 0, high preset 0x7FFF, low preset 0x8000, `irq` low and `pat_out` zero. A `configure` pulse clears status bits 15, 14 and 7 to 3, sets bit 1, and keeps bits 13 to 10 and 2.
- R2: A rising edge of `pulse_in` adds 1 to the accumulator when `count_dir`=1 and status bit 15 (up enable) is set. It subtracts 1 when `count_dir`=0 and bit 14 (down enable) is set. A held-high input, or a direction whose enable is clear, leaves the accumulator unchanged.
- R3: Counting up from 32767 gives -32768 and sets status bit 12 (overflow). Counting down from -32768 gives 32767 and sets status bit 11 (underflow).
- R4: Status bit 9 reads 1 exactly when accumulator >= high preset (signed). Bit 8 reads 1 exactly when accumulator <= low preset. Writes do not change either bit.
- R5: A counting step that takes the accumulator from below the high preset to at or above it sets status bit 13 (high reached). A step that takes it from above the low preset to at or below it is a low event. Loads and preset writes cause no events.
- R6: With status bit 1 (interrupt enable) set and bit 3 (pending) clear, an event sets its cause bit: 7 overflow, 6 underflow, 5 high, 4 low. It also sets bit 3, and `irq` is high from the next cycle. With bit 1 clear, no cause or pending bit is set.
- R7: An event that arrives while bit 3 is set and is not being acknowledged sets bit 2 (lost) and leaves the cause bits unchanged.
- R8: `irq_ack` clears bit 3 and lowers `irq` on the next cycle. The cause bits stay set until software writes them.
- R9: A write to the accumulator address is ignored unless status bit 10 (load request) is set. While bit 10 is set, counting is suspended. A write then loads the accumulator and clears bit 10.
- R10: On a high or low event, each `pat_out` bit whose `pat_mask` bit is 1 takes the matching `pat_src` bit. The other bits keep their value. Without an event, `pat_out` holds.
- R11: Status writes change only bits 15 to 10 and 7 to 1. Bit 0 always reads 0. `reg_rdata` is registered with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| configure | input | 1 | Reconfiguration pulse |
| pulse_in | input | 1 | Synchronised count pulse |
| count_dir | input | 1 | 1 counts up, 0 counts down |
| reg_addr | input | 2 | Word select: 0 status, 1 high preset, 2 accumulator, 3 low preset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Interrupt request (mirrors pending bit) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| pat_src | input | OW | Source pattern for output update |
| pat_mask | input | OW | Per-bit update mask |
| pat_out | output | OW | Registered pattern output |

## Verification
A vector table runs mixed up and down bursts through zero and into negative values. This separates a correct signed count from a stuck or one-directional one. Directed sequences then approach each preset from both sides, so that a real crossing can be told apart from a mere level test. They also fire a second event while one is still pending, which separates recording the loss from overwriting the cause. The two wrap points are reached through a guarded accumulator load. This shows both that the wrap arithmetic is right and that a wrap counts as a low or high crossing. Finally, a reconfiguration pulse shows which status bits survive it.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int SW = 16;

  localparam int B_UP   = 15;
  localparam int B_DN   = 14;
  localparam int B_DONE = 13;
  localparam int B_OVF  = 12;
  localparam int B_UNF  = 11;
  localparam int B_UPD  = 10;
  localparam int B_HI   = 9;
  localparam int B_LO   = 8;
  localparam int B_COVF = 7;
  localparam int B_CUNF = 6;
  localparam int B_CHI  = 5;
  localparam int B_CLO  = 4;
  localparam int B_PEND = 3;
  localparam int B_LOST = 2;
  localparam int B_IE   = 1;

  // writable status bits: 15..10 and 7..1
  localparam logic [SW-1:0] ST_WMASK = 16'hFCFE;
  // bits cleared by reconfiguration: 15, 14, 7..3
  localparam logic [SW-1:0] ST_CFGCLR = 16'hC0F8;
  localparam logic [SW-1:0] ST_RESET = 16'h0002;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_HIGH = 2'd1,
    A_ACC  = 2'd2,
    A_LOW  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic hi;
    logic lo;
  } ev_t;
endpackage

// File: rtl/pcnt_step.sv
module pcnt_step
  import pcnt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] acc,
  input  logic signed [DW-1:0] hi_p,
  input  logic signed [DW-1:0] lo_p,
  input  logic                 up,
  input  logic                 dn,
  output logic signed [DW-1:0] acc_nxt,
  output ev_t                  ev,
  output logic                 hi_flag,
  output logic                 lo_flag
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic stepping;
  logic now_hi, now_lo;

  assign hi_flag  = (acc >= hi_p);
  assign lo_flag  = (acc <= lo_p);
  assign stepping = up | dn;

  always_comb begin
    acc_nxt = acc;
    ev      = '0;
    if (up) begin
      acc_nxt = acc + DW'(1);
      ev.ovf  = (acc == MAXV);
    end else if (dn) begin
      acc_nxt = acc - DW'(1);
      ev.unf  = (acc == MINV);
    end
    now_hi = (acc_nxt >= hi_p);
    now_lo = (acc_nxt <= lo_p);
    ev.hi  = stepping & now_hi & ~hi_flag;
    ev.lo  = stepping & now_lo & ~lo_flag;
  end
endmodule

// File: rtl/pcnt_status.sv
module pcnt_status
  import pcnt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          configure,
  input  logic          wr_stat,
  input  logic [SW-1:0] wdata,
  input  logic          ack,
  input  ev_t           ev,
  input  logic          acc_loaded,
  output logic [SW-1:0] st,
  output logic          irq
);
  logic [SW-1:0] st_n;
  logic          pend_eff;
  logic          ev_any;

  assign ev_any = ev.ovf | ev.unf | ev.hi | ev.lo;
  assign irq    = st[B_PEND];

  always_comb begin
    st_n = st;
    if (wr_stat) st_n = wdata & ST_WMASK;
    if (ev.ovf) st_n[B_OVF]  = 1'b1;
    if (ev.unf) st_n[B_UNF]  = 1'b1;
    if (ev.hi)  st_n[B_DONE] = 1'b1;
    pend_eff = st[B_PEND] & ~ack;
    if (ack) st_n[B_PEND] = 1'b0;
    if (ev_any && st[B_IE]) begin
      if (pend_eff) begin
        st_n[B_LOST] = 1'b1;
      end else begin
        st_n[B_COVF] = st_n[B_COVF] | ev.ovf;
        st_n[B_CUNF] = st_n[B_CUNF] | ev.unf;
        st_n[B_CHI]  = st_n[B_CHI]  | ev.hi;
        st_n[B_CLO]  = st_n[B_CLO]  | ev.lo;
        st_n[B_PEND] = 1'b1;
      end
    end
    if (configure) begin
      st_n = (st & ~ST_CFGCLR) | ST_RESET;
    end
    if (acc_loaded) st_n[B_UPD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RESET;
    else     st <= st_n;
  end
endmodule

// File: rtl/pcnt_pattern.sv
module pcnt_pattern #(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [OW-1:0] src,
  input  logic [OW-1:0] mask,
  output logic [OW-1:0] q
);
  for (genvar i = 0; i < OW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                 q[i] <= 1'b0;
      else if (fire && mask[i]) q[i] <= src[i];
    end
  end
endmodule

// File: rtl/pulse_preset_counter.sv
module pulse_preset_counter
  import pcnt_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          configure,
  input  logic          pulse_in,
  input  logic          count_dir,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          irq_ack,
  input  logic [OW-1:0] pat_src,
  input  logic [OW-1:0] pat_mask,
  output logic [OW-1:0] pat_out
);
  localparam logic signed [DW-1:0] HI_RST = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] LO_RST = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] acc, hi_p, lo_p, acc_nxt;
  logic                 pulse_d;
  logic                 rise, up, dn;
  logic                 hi_flag, lo_flag;
  logic                 acc_loaded, ev_any;
  logic [SW-1:0]        st, st_view;
  ev_t                  ev;

  always_ff @(posedge clk) pulse_d <= pulse_in;

  assign rise = pulse_in & ~pulse_d;
  assign up   = rise &  count_dir & st[B_UP] & ~st[B_UPD];
  assign dn   = rise & ~count_dir & st[B_DN] & ~st[B_UPD];
  assign acc_loaded = reg_wr && (reg_addr == A_ACC) && st[B_UPD];
  assign ev_any = ev.ovf | ev.unf | ev.hi | ev.lo;

  pcnt_step #(.DW(DW)) u_step (
    .acc     (acc),
    .hi_p    (hi_p),
    .lo_p    (lo_p),
    .up      (up),
    .dn      (dn),
    .acc_nxt (acc_nxt),
    .ev      (ev),
    .hi_flag (hi_flag),
    .lo_flag (lo_flag)
  );

  pcnt_status u_status (
    .clk        (clk),
    .rst        (rst),
    .configure  (configure),
    .wr_stat    (reg_wr && (reg_addr == A_STAT)),
    .wdata      (reg_wdata[SW-1:0]),
    .ack        (irq_ack),
    .ev         (ev),
    .acc_loaded (acc_loaded),
    .st         (st),
    .irq        (irq)
  );

  pcnt_pattern #(.OW(OW)) u_pattern (
    .clk  (clk),
    .rst  (rst),
    .fire (ev.hi | ev.lo),
    .src  (pat_src),
    .mask (pat_mask),
    .q    (pat_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      hi_p <= HI_RST;
      lo_p <= LO_RST;
    end else begin
      if (acc_loaded) acc <= reg_wdata;
      else            acc <= acc_nxt;
      if (reg_wr && reg_addr == A_HIGH) hi_p <= reg_wdata;
      if (reg_wr && reg_addr == A_LOW)  lo_p <= reg_wdata;
    end
  end

  always_comb begin
    st_view       = st;
    st_view[B_HI] = hi_flag;
    st_view[B_LO] = lo_flag;
    st_view[0]    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_STAT:  reg_rdata <= DW'(st_view);
        A_HIGH:  reg_rdata <= hi_p;
        A_ACC:   reg_rdata <= acc;
        default: reg_rdata <= lo_p;
      endcase
    end
  end
endmodule

// File: rtl/pulse_preset_counter_chk.sv
module pulse_preset_counter_chk #(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          configure,
  input logic          pulse_in,
  input logic          count_dir,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq,
  input logic          irq_ack,
  input logic [OW-1:0] pat_out,
  input logic [15:0]   st,
  input logic [DW-1:0] acc,
  input logic          ev_any,
  input logic          ev_fire
);
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  a_r1_configure: assert property (@(posedge clk) disable iff (rst)
    configure |=> (st[15:14] == 2'b00 && st[7:3] == 5'd0 && st[1]));

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && !$past(pulse_in) && count_dir && st[15] && !st[10] && acc != MAXV)
    |=> acc == DW'($past(acc) + 1'b1));

  a_r3_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && !$past(pulse_in) && count_dir && st[15] && !st[10] && acc == MAXV && !configure)
    |=> (acc == MINV && st[12]));

  a_r7_lost: assert property (@(posedge clk) disable iff (rst)
    (st[3] && st[1] && ev_any && !irq_ack && !configure) |=> st[2]);

  a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !ev_any) |=> !irq);

  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && st[10]) |=> (acc == $past(reg_wdata) && !st[10]));

  a_r10_pattern_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_fire |=> $stable(pat_out));
endmodule

bind pulse_preset_counter pulse_preset_counter_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .configure (configure),
  .pulse_in  (pulse_in),
  .count_dir (count_dir),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .irq_ack   (irq_ack),
  .pat_out   (pat_out),
  .st        (st),
  .acc       (acc),
  .ev_any    (ev_any),
  .ev_fire   (ev.hi | ev.lo)
);

// File: tb/pulse_preset_counter_tb.sv
module pulse_preset_counter_tb;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int OW = 16;
  localparam int NVEC = 5;
  // {dir, pulse count, expected accumulator}
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {1'b1, 8'd5,  16'h0005},
    {1'b0, 8'd8,  16'hFFFD},
    {1'b1, 8'd3,  16'h0000},
    {1'b0, 8'd1,  16'hFFFF},
    {1'b1, 8'd10, 16'h0009}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          configure = 1'b0;
  logic          pulse_in = 1'b0;
  logic          count_dir = 1'b1;
  logic [1:0]    reg_addr = 2'd0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;
  logic          irq_ack = 1'b0;
  logic [OW-1:0] pat_src = '0;
  logic [OW-1:0] pat_mask = '0;
  logic [OW-1:0] pat_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] rv;

  always #(CLK_P/2) clk = ~clk;

  pulse_preset_counter #(.DW(DW), .OW(OW)) u_dut (
    .clk(clk), .rst(rst), .configure(configure), .pulse_in(pulse_in),
    .count_dir(count_dir), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .irq_ack(irq_ack), .pat_src(pat_src), .pat_mask(pat_mask),
    .pat_out(pat_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    tick();
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic d);
    count_dir = d; pulse_in = 1'b1;
    tick();
    pulse_in = 1'b0;
    tick();
  endtask

  task automatic run_tests();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 pat_out", pat_out, 0);
    rd(2'd0, rv); check("R1 status", rv, 16'h0002);
    rd(2'd2, rv); check("R1 acc", rv, 16'h0000);
    rd(2'd1, rv); check("R1 high", rv, 16'h7FFF);
    rd(2'd3, rv); check("R1 low", rv, 16'h8000);

    // R2 table of bursts
    wr(2'd0, 16'hC002);
    for (int i = 0; i < NVEC; i++) begin
      for (int k = 0; k < int'(VEC[i][23:16]); k++) pulse(VEC[i][24]);
      rd(2'd2, rv); check("R2 burst acc", rv, {16'h0, VEC[i][15:0]});
    end

    // R2 held-high input counts once
    count_dir = 1'b1; pulse_in = 1'b1;
    repeat (4) tick();
    pulse_in = 1'b0; tick();
    rd(2'd2, rv); check("R2 held high", rv, 16'd10);

    // R2 up enable clear
    wr(2'd0, 16'h4002);
    pulse(1'b1);
    rd(2'd2, rv); check("R2 up disabled", rv, 16'd10);
    wr(2'd0, 16'hC002);

    // R4 / R11 limit flags, read-only bits, bit 0
    wr(2'd1, 16'd12);
    wr(2'd3, 16'd10);
    wr(2'd0, 16'hC303);
    rd(2'd0, rv); check("R4 R11 flags read-only", rv, 16'hC102);

    // R5 R6 R10 high event
    pat_src = 16'hA5A5; pat_mask = 16'h00FF;
    pulse(1'b1);
    check("R10 no event hold", pat_out, 16'h0000);
    pulse(1'b1);
    check("R6 irq raised", irq, 1);
    check("R10 masked update", pat_out, 16'h00A5);
    rd(2'd0, rv); check("R5 R6 status high", rv, 16'hE22A);

    // R7 lost: low event while pending
    pat_src = 16'h5A5A; pat_mask = 16'h0F0F;
    pulse(1'b1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    rd(2'd0, rv); check("R7 lost kept cause", rv, 16'hE12E);
    check("R10 low event update", pat_out, 16'h0AAA);

    // R8 acknowledge
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    check("R8 irq low", irq, 0);
    rd(2'd0, rv); check("R8 causes kept", rv, 16'hE126);
    wr(2'd0, 16'hC002);
    rd(2'd0, rv); check("R11 software clear", rv, 16'hC102);

    // R6 interrupts disabled
    wr(2'd0, 16'hC000);
    pat_src = 16'hFFFF; pat_mask = 16'hF000;
    pulse(1'b1); pulse(1'b1);
    check("R6 no irq when disabled", irq, 0);
    rd(2'd0, rv); check("R6 R5 done only", rv, 16'hE200);
    check("R10 update without irq", pat_out, 16'hFAAA);

    // R9 guarded load
    wr(2'd2, 16'h7FFF);
    rd(2'd2, rv); check("R9 write ignored", rv, 16'd12);
    wr(2'd0, 16'hC402);
    pulse(1'b1);
    rd(2'd2, rv); check("R9 count suspended", rv, 16'd12);
    wr(2'd2, 16'h7FFF);
    rd(2'd2, rv); check("R9 loaded", rv, 16'h7FFF);
    rd(2'd0, rv); check("R9 request cleared", rv, 16'hC202);

    // R3 overflow wrap
    pulse(1'b1);
    rd(2'd2, rv); check("R3 wrap up", rv, 16'h8000);
    rd(2'd0, rv); check("R3 overflow status", rv, 16'hD19A);
    check("R3 irq", irq, 1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    // R3 underflow wrap
    pulse(1'b0);
    rd(2'd2, rv); check("R3 wrap down", rv, 16'h7FFF);
    rd(2'd0, rv); check("R3 underflow status", rv, 16'hFAFA);

    // R1 reconfiguration
    configure = 1'b1; tick(); configure = 1'b0;
    check("R1 config irq", irq, 0);
    rd(2'd0, rv); check("R1 config status", rv, 16'h3A02);
    rd(2'd3, rv); check("R11 low readback", rv, 16'd10);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule